// File: doc/BRIEF.md
# Peripheral Access Filter Unit

The filter stands in front of one peripheral's register port and decides, for every bus transaction, whether it may reach the peripheral. Each transaction arrives with a 3-bit compartment identifier, a secure bit, a privilege bit and a read/write flag. A single rule register holds the secure level required, the privilege level required, a compartment-filter enable and one authorised compartment identifier. The transaction is compared with this rule in the same cycle that it is presented.

Allowed transactions are forwarded to the peripheral port unchanged, and read data comes back upstream one cycle later. Blocked transactions never reach the peripheral. A blocked write is dropped, a blocked read returns zero, and the master still receives its normal response in the next cycle, so it is never stalled and never sees an error. For each blocked access a one-cycle event goes to the illegal-access controller. Only a secure, privileged write on the separate configuration port can change the rule.

Top module: `perif_gate`

## Requirements
- R1: When the rule requires secure (bit 0 of the rule register), a transaction with its secure bit at 0 is blocked. When the rule requires privileged (bit 1), a transaction with its privilege bit at 0 is blocked. A rule level of 0 accepts both values of the bit.
- R2: When compartment filtering is off (bit 2 of the rule register at 0), a transaction that meets the secure and privilege levels is forwarded, whatever its compartment identifier and whatever value bits 5:3 hold.
- R3: When compartment filtering is on (bit 2 at 1), a transaction is forwarded only if its compartment identifier equals bits 5:3 of the rule register and it also meets the secure and privilege levels.
- R4: A blocked write does not raise `pe_req`, and the peripheral's contents are unchanged.
- R5: A blocked read completes with `up_rdata` equal to zero.
- R6: Each blocked access raises `ill_evt` for exactly the one cycle after the request cycle. `ill_evt` stays low after an allowed access or an idle cycle.
- R7: Every request cycle, allowed or blocked, is answered by `up_rvalid` high in the next cycle. An allowed read returns the peripheral's data in that response.
- R8: A configuration write changes the rule register only when `cfg_sec` and `cfg_priv` are both 1. The new rule is visible on `cfg_rdata`, and applies to transactions, from the next cycle.
- R9: After reset the rule register reads 6'b000011: secure and privileged required, compartment filtering off, identifier 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream request, one cycle per transaction |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | AW | Register address |
| up_wdata | input | DW | Write data |
| up_cid | input | 3 | Compartment identifier of the master |
| up_sec | input | 1 | Transaction is secure |
| up_priv | input | 1 | Transaction is privileged |
| up_rvalid | output | 1 | Response, one cycle after each request |
| up_rdata | output | DW | Read data, or zero for a blocked read |
| pe_req | output | 1 | Request forwarded to the peripheral |
| pe_we | output | 1 | Forwarded write flag |
| pe_addr | output | AW | Forwarded address |
| pe_wdata | output | DW | Forwarded write data |
| pe_rdata | input | DW | Peripheral read data for the presented address |
| cfg_wr | input | 1 | Rule register write strobe |
| cfg_wdata | input | 6 | New rule value |
| cfg_sec | input | 1 | Configuration write is secure |
| cfg_priv | input | 1 | Configuration write is privileged |
| cfg_rdata | output | 6 | Current rule value |
| ill_evt | output | 1 | Illegal-access event pulse |

## Verification
The bound checker decodes the rule from `cfg_rdata` on every cycle. On each cycle it checks that an access failing the secure, privilege or compartment test never raises `pe_req`, and that an access passing all three always does. It also checks that every request is answered in the next cycle, that a blocked read returns zero, that the event pulse matches the blocked accesses one to one, and that an unqualified configuration write leaves the rule unchanged. Two things need the bench's scenarios: that a dropped write really leaves the peripheral's storage untouched, and that an allowed read returns exactly what an earlier allowed write stored. The same holds for the reset value of the rule and its return to that value after a second reset.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int PG_CIDW = 3;

  typedef struct packed {
    logic [PG_CIDW-1:0] cid;
    logic               cid_en;
    logic               priv_req;
    logic               sec_req;
  } pg_rule_t;

  localparam int PG_RULEW = $bits(pg_rule_t);

  localparam pg_rule_t PG_RULE_RST = '{cid: '0, cid_en: 1'b0,
                                       priv_req: 1'b1, sec_req: 1'b1};
endpackage

// File: rtl/pg_rule_reg.sv
module pg_rule_reg
  import pg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [PG_RULEW-1:0] wdata,
  input  logic                wr_sec,
  input  logic                wr_priv,
  output pg_rule_t            rule
);
  pg_rule_t rule_q, rule_d;
  logic     rule_en;

  // only a trusted master may reprogram the rule
  always_comb begin
    rule_en = wr & wr_sec & wr_priv;
    rule_d  = pg_rule_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rule_q <= PG_RULE_RST;
    else if (rule_en) rule_q <= rule_d;
  end

  assign rule = rule_q;
endmodule

// File: rtl/pg_rule_check.sv
module pg_rule_check
  import pg_pkg::*;
(
  input  pg_rule_t             rule,
  input  logic [PG_CIDW-1:0]   cid,
  input  logic                 sec,
  input  logic                 priv,
  output logic                 allow
);
  logic [PG_CIDW-1:0] bit_eq;

  genvar g;
  generate
    for (g = 0; g < PG_CIDW; g++) begin : g_cid_cmp
      assign bit_eq[g] = ~(cid[g] ^ rule.cid[g]);
    end
  endgenerate

  logic sec_ok, priv_ok, cid_ok;

  always_comb begin
    sec_ok  = sec  | ~rule.sec_req;
    priv_ok = priv | ~rule.priv_req;
    cid_ok  = ~rule.cid_en | (&bit_eq);
    allow   = sec_ok & priv_ok & cid_ok;
  end
endmodule

// File: rtl/pg_resp.sv
module pg_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic          allow,
  input  logic [DW-1:0] pe_rdata,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          evt
);
  logic          rvalid_q, rvalid_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          evt_q, evt_d;
  logic          data_en;

  always_comb begin
    rvalid_d = req;
    evt_d    = req & ~allow;
    data_en  = req;
    rdata_d  = (allow & ~we) ? pe_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      evt_q    <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (data_en) rdata_q <= rdata_d;
  end

  assign rvalid = rvalid_q;
  assign rdata  = rvalid_q ? rdata_q : '0;
  assign evt    = evt_q;
endmodule

// File: rtl/perif_gate.sv
module perif_gate
  import pg_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_req,
  input  logic                up_we,
  input  logic [AW-1:0]       up_addr,
  input  logic [DW-1:0]       up_wdata,
  input  logic [PG_CIDW-1:0]  up_cid,
  input  logic                up_sec,
  input  logic                up_priv,
  output logic                up_rvalid,
  output logic [DW-1:0]       up_rdata,
  output logic                pe_req,
  output logic                pe_we,
  output logic [AW-1:0]       pe_addr,
  output logic [DW-1:0]       pe_wdata,
  input  logic [DW-1:0]       pe_rdata,
  input  logic                cfg_wr,
  input  logic [PG_RULEW-1:0] cfg_wdata,
  input  logic                cfg_sec,
  input  logic                cfg_priv,
  output logic [PG_RULEW-1:0] cfg_rdata,
  output logic                ill_evt
);
  pg_rule_t rule;
  logic     allow;

  pg_rule_reg u_rule (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wdata   (cfg_wdata),
    .wr_sec  (cfg_sec),
    .wr_priv (cfg_priv),
    .rule    (rule)
  );

  pg_rule_check u_check (
    .rule  (rule),
    .cid   (up_cid),
    .sec   (up_sec),
    .priv  (up_priv),
    .allow (allow)
  );

  pg_resp #(.DW(DW)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (up_req),
    .we       (up_we),
    .allow    (allow),
    .pe_rdata (pe_rdata),
    .rvalid   (up_rvalid),
    .rdata    (up_rdata),
    .evt      (ill_evt)
  );

  // blocked traffic never leaves the filter
  always_comb begin
    pe_req   = up_req & allow;
    pe_we    = up_we & pe_req;
    pe_addr  = pe_req ? up_addr  : '0;
    pe_wdata = pe_req ? up_wdata : '0;
  end

  assign cfg_rdata = rule;
endmodule

// File: rtl/perif_gate_chk.sv
module perif_gate_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_req,
  input logic          up_we,
  input logic [2:0]    up_cid,
  input logic          up_sec,
  input logic          up_priv,
  input logic          up_rvalid,
  input logic [DW-1:0] up_rdata,
  input logic          pe_req,
  input logic          cfg_wr,
  input logic          cfg_sec,
  input logic          cfg_priv,
  input logic [5:0]    cfg_rdata,
  input logic          ill_evt
);
  logic sec_bad, priv_bad, cid_bad, ok;
  always_comb begin
    sec_bad  = cfg_rdata[0] && !up_sec;
    priv_bad = cfg_rdata[1] && !up_priv;
    cid_bad  = cfg_rdata[2] && (up_cid != cfg_rdata[5:3]);
    ok       = !sec_bad && !priv_bad && !cid_bad;
  end

  a_r1_level_block: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && (sec_bad || priv_bad)) |-> !pe_req);

  a_r2_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && ok) |-> pe_req);

  a_r3_cid_block: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && cid_bad) |-> !pe_req);

  a_r4_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_req) |-> !pe_req);

  a_r5_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !up_we && !ok) |=> (up_rdata == '0));

  a_r6_evt_on_block: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !ok) |=> ill_evt);

  a_r6_evt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_req || ok) |=> !ill_evt);

  a_r7_response: assert property (@(posedge clk) disable iff (!rst_n)
    up_req |=> up_rvalid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !up_req |=> !up_rvalid);

  a_r8_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr || !cfg_sec || !cfg_priv) |=> $stable(cfg_rdata));
endmodule

bind perif_gate perif_gate_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_req    (up_req),
  .up_we     (up_we),
  .up_cid    (up_cid),
  .up_sec    (up_sec),
  .up_priv   (up_priv),
  .up_rvalid (up_rvalid),
  .up_rdata  (up_rdata),
  .pe_req    (pe_req),
  .cfg_wr    (cfg_wr),
  .cfg_sec   (cfg_sec),
  .cfg_priv  (cfg_priv),
  .cfg_rdata (cfg_rdata),
  .ill_evt   (ill_evt)
);

// File: tb/perif_gate_bench.sv
module perif_gate_bench;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk, rst_n;
  logic          up_req, up_we, up_sec, up_priv;
  logic [AW-1:0] up_addr;
  logic [DW-1:0] up_wdata;
  logic [2:0]    up_cid;
  logic          up_rvalid;
  logic [DW-1:0] up_rdata;
  logic          pe_req, pe_we;
  logic [AW-1:0] pe_addr;
  logic [DW-1:0] pe_wdata, pe_rdata;
  logic          cfg_wr, cfg_sec, cfg_priv;
  logic [5:0]    cfg_wdata, cfg_rdata;
  logic          ill_evt;

  int checks = 0;
  int errors = 0;

  perif_gate #(.AW(AW), .DW(DW)) u_perif_gate (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_cid(up_cid),
    .up_sec(up_sec), .up_priv(up_priv), .up_rvalid(up_rvalid),
    .up_rdata(up_rdata), .pe_req(pe_req), .pe_we(pe_we),
    .pe_addr(pe_addr), .pe_wdata(pe_wdata), .pe_rdata(pe_rdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_sec(cfg_sec),
    .cfg_priv(cfg_priv), .cfg_rdata(cfg_rdata), .ill_evt(ill_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench-side peripheral: four words of storage
  logic [DW-1:0] mem [4];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) mem[k] <= 32'h0BAD_0000 + k;
    end else if (pe_req && pe_we) begin
      mem[pe_addr[1:0]] <= pe_wdata;
    end
  end
  assign pe_rdata = mem[pe_addr[1:0]];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] v, input logic s, input logic p);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v; cfg_sec = s; cfg_priv = p;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // one access: returns forwarded flag, response valid, data and event
  task automatic access(input logic we, input logic [1:0] a, input logic [DW-1:0] d,
                        input logic [2:0] c, input logic s, input logic p,
                        output logic fwd, output logic rv,
                        output logic [DW-1:0] rd, output logic ev);
    @(negedge clk);
    up_req = 1'b1; up_we = we; up_addr = AW'(a); up_wdata = d;
    up_cid = c; up_sec = s; up_priv = p;
    #1 fwd = pe_req;
    @(negedge clk);
    up_req = 1'b0; up_we = 1'b0;
    rv = up_rvalid; rd = up_rdata; ev = ill_evt;
  endtask

  // vector: [11] expect allow, [10] priv, [9] sec, [8:6] cid, [5:0] rule
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    12'b1_1_1_101_000011,  // R1 secure+priv met
    12'b0_1_0_101_000011,  // R1 non-secure blocked
    12'b0_0_1_101_000011,  // R1 unprivileged blocked
    12'b1_0_0_010_000000,  // R1 open rule
    12'b1_0_1_000_000001,  // R1 secure only
    12'b1_1_0_011_000010,  // R1 privileged only
    12'b1_0_0_011_011100,  // R3 cid match
    12'b0_0_0_100_011100,  // R3 cid mismatch
    12'b1_1_1_111_111111,  // R3 all rules met
    12'b0_1_0_111_111111,  // R3 cid ok, non-secure
    12'b0_1_1_110_111111,  // R3 cid wrong
    12'b1_0_0_001_101000   // R2 cid field ignored when filter off
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic fwd, rv, ev;
    logic [DW-1:0] rd;
    up_req = 0; up_we = 0; up_addr = '0; up_wdata = '0; up_cid = '0;
    up_sec = 0; up_priv = 0; cfg_wr = 0; cfg_wdata = '0; cfg_sec = 0; cfg_priv = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R9 reset rule", DW'(cfg_rdata), DW'(6'b000011));
    chk("R7 idle no response", DW'(up_rvalid), 0);
    chk("R6 idle no event", DW'(ill_evt), 0);

    for (int i = 0; i < NV; i++) begin
      logic          exp;
      logic [1:0]    a;
      logic [DW-1:0] d, old;
      exp = VEC[i][11];
      a   = 2'(i);
      d   = 32'hA500_0000 | i;
      cfg_write(VEC[i][5:0], 1'b1, 1'b1);
      chk("R8 trusted rule write", DW'(cfg_rdata), DW'(VEC[i][5:0]));
      old = mem[a];
      access(1'b1, a, d, VEC[i][8:6], VEC[i][9], VEC[i][10], fwd, rv, rd, ev);
      chk("R1 R2 R3 forward decision", DW'(fwd), DW'(exp));
      chk("R6 event on write", DW'(ev), DW'(!exp));
      chk("R7 write answered", DW'(rv), 1);
      chk("R4 storage after write", mem[a], exp ? d : old);
      access(1'b0, a, '0, VEC[i][8:6], VEC[i][9], VEC[i][10], fwd, rv, rd, ev);
      chk("R5 R7 read data", rd, exp ? d : '0);
      chk("R6 event on read", DW'(ev), DW'(!exp));
    end

    // untrusted rule writes are ignored
    cfg_write(6'b000011, 1'b1, 1'b1);
    cfg_write(6'b000000, 1'b0, 1'b1);
    chk("R8 non-secure rule write ignored", DW'(cfg_rdata), DW'(6'b000011));
    cfg_write(6'b000000, 1'b1, 1'b0);
    chk("R8 unprivileged rule write ignored", DW'(cfg_rdata), DW'(6'b000011));
    access(1'b0, 2'd0, '0, 3'd0, 1'b0, 1'b0, fwd, rv, rd, ev);
    chk("R8 rule still blocks", DW'(fwd), 0);

    // event lasts one cycle only
    access(1'b0, 2'd1, '0, 3'd0, 1'b0, 1'b0, fwd, rv, rd, ev);
    chk("R6 event raised", DW'(ev), 1);
    @(negedge clk);
    chk("R6 event one cycle", DW'(ill_evt), 0);
    chk("R7 single response", DW'(up_rvalid), 0);

    // reset brings the rule back
    cfg_write(6'b101100, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rule after second reset", DW'(cfg_rdata), DW'(6'b000011));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule